// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a pipelined synchronous SRAM whose data bus can turn between reads and writes with no idle cycle. Each clock edge registers one command (address, read/write, chip enables and byte enables). The data transfer for that command happens in the following cycle. Read data flows from the array straight onto the bidirectional data bus without an output register. Write data is taken from the bus on the edge that closes that data cycle. Commands can therefore be issued on every cycle in any mix of reads and writes.

A load cycle can start a four-beat burst. Cycles with the advance input high then step an internal beat counter in linear or interleaved order. The command type stays fixed for the whole burst. A clock-enable input and a sleep input freeze the whole pipeline. An asynchronous output enable can release the bus at any time. Three chip-enable inputs select the device. The array is a small parameterised stand-in for a full-size part and is split into 9-bit byte lanes.

Top module: `zbt_sram_model`

## Requirements
- R1: A command registered on a clock edge has its data cycle between that edge and the next one, and a read may follow a write (or a write a read) on the very next edge with no idle cycle, returning the word that write stored.
- R2: During the data cycle of a read, `dq` carries the array word at the command address, driven combinationally in that same cycle with no extra register stage.
- R3: On an edge where `cke_n` is 1, every synchronous input is ignored and all internal state is held: a pending read keeps driving the same word, and a pending write is not performed until the next enabled edge.
- R4: The device is selected only when `ce_a_n`=0, `ce_b_n`=0 and `ce_c`=1. A load cycle (`adv`=0) without selection starts a deselect and ends any burst: the bus is high impedance in the following cycle, while a transfer already pending still completes.
- R5: The device never drives `dq` during the data cycle of a write; the value on the bus is the one applied from outside.
- R6: `be_n[i]`=0 enables byte lane i, bits [9i+8:9i]. The byte enables are sampled with each write command and each burst-write beat, and only enabled lanes are written when the data arrives.
- R7: `be_n` has no effect on reads, and `rd_wr` (1 = read, 0 = write) has no effect on advance cycles: the burst keeps the type sampled at its load.
- R8: After a selected load at address A, each `adv`=1 cycle issues the next beat. Beat k (k = 0..3, wrapping) keeps the upper address bits of A and uses low two bits (A[1:0]+k) mod 4 when `burst_order`=0, or A[1:0] XOR k when `burst_order`=1.
- R9: An `adv`=1 cycle with no burst in progress (after reset or after a deselect) is a no-op, and the bus is high impedance in the following cycle.
- R10: When `oe_n` is 1, `dq` is high impedance immediately, whatever the clocked state.
- R11: `sleep`=1 freezes the block exactly as `cke_n`=1 does, and the array contents are kept.
- R12: A synchronous reset (`rst`=1 on an edge) empties the pipeline and ends any burst, discarding a write whose data cycle ends on that edge. The bus is then high impedance. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the pipeline, active high |
| cke_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Sleep, active high; freezes the block |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| adv | input | 1 | 0 = load a new command, 1 = advance the burst |
| rd_wr | input | 1 | 1 = read, 0 = write; sampled on loads only |
| be_n | input | DATA_W/BYTE_W | Byte-lane write enables, active low |
| addr | input | $clog2(DEPTH) | Word address, sampled on loads |
| burst_order | input | 1 | 0 = linear beat order, 1 = interleaved; keep static |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | DATA_W | Bidirectional data bus |

## Verification
The hardest situation to reach from the ports is a stall that lands in the middle of a burst while a write beat is pending. This shows whether the held write, the held beat counter and the operation locked at load all survive the freeze. The stimulus mixes clock-enable, sleep, deselect and advance cycles at random rates from a fixed seed, with long bursts in both beat orders. This brings such collisions about many times. A per-cycle reference model predicts every bus value, including high impedance and contention during writes. Directed sequences cover turnaround, masked writes, the idle advance, and array retention across reset.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
   parameter int AW = 6,
   parameter int CW = 2
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] beat,
   input  logic          interleave,
   output logic [AW-1:0] beat_addr
);
   logic [CW-1:0] low;

   always_comb begin
      if (interleave) low = base[CW-1:0] ^ beat;
      else            low = base[CW-1:0] + beat;
   end

   generate
      if (AW > CW) begin : g_upper
         assign beat_addr = {base[AW-1:CW], low};
      end else begin : g_flat
         assign beat_addr = low;
      end
   endgenerate
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
   import zbt_pkg::*;
#(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          adv,
   input  logic          sel,
   input  logic          rd_wr,
   input  logic [NB-1:0] be_n,
   input  logic [AW-1:0] addr,
   input  logic          interleave,
   output logic          dp_valid,
   output op_e           dp_op,
   output logic [AW-1:0] dp_addr,
   output logic [NB-1:0] dp_be_n
);
   logic          busy_q;
   op_e           op_q;
   logic [AW-1:0] base_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic [AW-1:0] next_beat;

   assign cnt_nx = cnt_q + 1'b1;

   zbt_burst_seq #(.AW(AW), .CW(CW)) u_seq (
      .base       (base_q),
      .beat       (cnt_nx),
      .interleave (interleave),
      .beat_addr  (next_beat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q   <= 1'b0;
         op_q     <= OP_READ;
         base_q   <= '0;
         cnt_q    <= '0;
         dp_valid <= 1'b0;
         dp_op    <= OP_READ;
         dp_addr  <= '0;
         dp_be_n  <= '1;
      end else if (en) begin
         if (!adv) begin
            if (sel) begin
               busy_q   <= 1'b1;
               op_q     <= rd_wr ? OP_READ : OP_WRITE;
               base_q   <= addr;
               cnt_q    <= '0;
               dp_valid <= 1'b1;
               dp_op    <= rd_wr ? OP_READ : OP_WRITE;
               dp_addr  <= addr;
               dp_be_n  <= be_n;
            end else begin
               busy_q   <= 1'b0;
               dp_valid <= 1'b0;
            end
         end else if (busy_q) begin
            cnt_q    <= cnt_nx;
            dp_valid <= 1'b1;
            dp_op    <= op_q;
            dp_addr  <= next_beat;
            dp_be_n  <= be_n;
         end else begin
            dp_valid <= 1'b0;
         end
      end
   end

   a_r3_freeze_holds: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(dp_valid) && $stable(dp_op) && $stable(dp_addr) && $stable(dp_be_n));

   a_r4_deselect_idle: assert property (@(posedge clk) disable iff (rst)
      en && !adv && !sel |=> !dp_valid);

   a_r9_idle_advance: assert property (@(posedge clk) disable iff (rst)
      en && adv && !busy_q |=> !dp_valid);

   a_r1_load_next_cycle: assert property (@(posedge clk) disable iff (rst)
      en && !adv && sel |=> dp_valid && dp_addr == $past(addr)
                            && (dp_op == OP_READ) == $past(rd_wr));

   a_r7_type_locked: assert property (@(posedge clk) disable iff (rst)
      en && adv && busy_q |=> dp_valid && dp_op == $past(op_q));

   a_r12_reset_empties: assert property (@(posedge clk)
      rst |=> !dp_valid && !busy_q);
endmodule

// File: rtl/zbt_lane_mem.sv
module zbt_lane_mem #(
   parameter int DEPTH  = 64,
   parameter int BYTE_W = 9,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/zbt_sram_model.sv
module zbt_sram_model
   import zbt_pkg::*;
#(
   parameter int DATA_W    = 36,
   parameter int BYTE_W    = 9,
   parameter int DEPTH     = 64,
   parameter int BURST_LEN = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cke_n,
   input  logic                       sleep,
   input  logic                       ce_a_n,
   input  logic                       ce_b_n,
   input  logic                       ce_c,
   input  logic                       adv,
   input  logic                       rd_wr,
   input  logic [DATA_W/BYTE_W-1:0]   be_n,
   input  logic [$clog2(DEPTH)-1:0]   addr,
   input  logic                       burst_order,
   input  logic                       oe_n,
   inout  wire  [DATA_W-1:0]          dq
);
   localparam int NB = DATA_W / BYTE_W;
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(BURST_LEN);

   generate
      if (NB * BYTE_W != DATA_W) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if ((1 << AW) != DEPTH || DEPTH < BURST_LEN) begin : g_bad_depth
         $error("DEPTH must be a power of two not below BURST_LEN");
      end
      if ((1 << CW) != BURST_LEN || BURST_LEN < 2) begin : g_bad_burst
         $error("BURST_LEN must be a power of two of at least 2");
      end
   endgenerate

   logic          en;
   logic          sel;
   logic          dp_valid;
   op_e           dp_op;
   logic [AW-1:0] dp_addr;
   logic [NB-1:0] dp_be_n;
   logic [DATA_W-1:0] rdata;
   logic          rd_drive;
   logic          wr_commit;

   assign en  = !cke_n && !sleep;
   assign sel = !ce_a_n && !ce_b_n && ce_c;

   zbt_cmd_pipe #(.AW(AW), .NB(NB), .CW(CW)) u_pipe (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .adv        (adv),
      .sel        (sel),
      .rd_wr      (rd_wr),
      .be_n       (be_n),
      .addr       (addr),
      .interleave (burst_order),
      .dp_valid   (dp_valid),
      .dp_op      (dp_op),
      .dp_addr    (dp_addr),
      .dp_be_n    (dp_be_n)
   );

   assign wr_commit = en && !rst && dp_valid && (dp_op == OP_WRITE);

   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         zbt_lane_mem #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_mem (
            .clk   (clk),
            .we    (wr_commit && !dp_be_n[i]),
            .addr  (dp_addr),
            .wdata (dq[i*BYTE_W +: BYTE_W]),
            .rdata (rdata[i*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   assign rd_drive = dp_valid && (dp_op == OP_READ) && !oe_n;
   assign dq = rd_drive ? rdata : {DATA_W{1'bz}};

   a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
      dp_valid && dp_op == OP_WRITE |-> !rd_drive);

   a_r11_sleep_no_commit: assert property (@(posedge clk) disable iff (rst)
      sleep |-> !wr_commit);
endmodule

// File: tb/sim_zbt_sram_model.sv
`timescale 1ns/1ps
module sim_zbt_sram_model;
   localparam int W = 36, BW = 9, NB = 4, D = 64, AW = 6;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1, cke_n = 1'b0, sleep = 1'b0, ce_a_n = 1'b0, ce_b_n = 1'b0, ce_c = 1'b1;
   logic adv = 1'b1, rd_wr = 1'b1, order = 1'b0, oe_n = 1'b0;
   logic [NB-1:0] be_n = '1;
   logic [AW-1:0] addr = '0;
   wire  [W-1:0]  dq;
   logic [W-1:0]  tb_dq = '0;
   logic          tb_drv = 1'b0;
   assign dq = tb_drv ? tb_dq : {W{1'bz}};

   zbt_sram_model #(.DATA_W(W), .BYTE_W(BW), .DEPTH(D), .BURST_LEN(4)) u0 (
      .clk(clk), .rst(rst), .cke_n(cke_n), .sleep(sleep), .ce_a_n(ce_a_n),
      .ce_b_n(ce_b_n), .ce_c(ce_c), .adv(adv), .rd_wr(rd_wr), .be_n(be_n),
      .addr(addr), .burst_order(order), .oe_n(oe_n), .dq(dq));

   // reference model
   logic [W-1:0]  m_mem [D];
   logic          m_busy = 1'b0, m_wr = 1'b0, pv = 1'b0, pw = 1'b0, armed = 1'b0;
   logic [AW-1:0] m_base = '0, pa = '0;
   logic [1:0]    m_cnt = '0;
   logic [NB-1:0] pbe = '1;
   string         kind = "R12";
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   function automatic logic [AW-1:0] beat(input logic [AW-1:0] b, input logic [1:0] k,
                                          input logic ord);
      logic [1:0] lo;
      lo = ord ? (b[1:0] ^ k) : (b[1:0] + k);
      return {b[AW-1:2], lo};
   endfunction

   function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                          input logic [NB-1:0] en_n);
      logic [W-1:0] r;
      r = old;
      for (int i = 0; i < NB; i++)
         if (!en_n[i]) r[i*BW +: BW] = nw[i*BW +: BW];
      return r;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s at %0t: dq=%h expected %h", tag, $time, got, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic ck, input logic sl, input logic a,
                      input logic b, input logic c, input logic ad, input logic rw,
                      input logic [NB-1:0] be, input logic [AW-1:0] ad_, input logic o,
                      input string tag);
      logic [63:0] rnd;
      logic [W-1:0] exp;
      string t;
      @(negedge clk);
      rst = r; cke_n = ck; sleep = sl; ce_a_n = a; ce_b_n = b; ce_c = c;
      adv = ad; rd_wr = rw; be_n = be; addr = ad_; oe_n = o;
      rnd = {$urandom(), $urandom()};
      tb_dq = rnd[W-1:0];
      tb_drv = pv && pw;
      #1;
      if (armed) begin
         if (pv && pw) begin
            check((tag != "") ? tag : "R5", dq, tb_dq);
         end else begin
            if (o) t = "R10"; else t = kind;
            if (tag != "") t = tag;
            exp = (pv && !o) ? m_mem[pa] : {W{1'bz}};
            check(t, dq, exp);
         end
      end
      @(posedge clk);
      if (r) begin
         pv = 1'b0; m_busy = 1'b0; kind = "R12"; armed = 1'b1;
      end else if (!(ck || sl)) begin
         if (pv && pw) m_mem[pa] = merge(m_mem[pa], tb_dq, pbe);
         if (!ad) begin
            if (!a && !b && c) begin
               m_busy = 1'b1; m_wr = !rw; m_base = ad_; m_cnt = 2'd0;
               pv = 1'b1; pw = !rw; pa = ad_; pbe = be; kind = "R2";
            end else begin
               m_busy = 1'b0; pv = 1'b0; kind = "R4";
            end
         end else if (m_busy) begin
            m_cnt = m_cnt + 2'd1;
            pv = 1'b1; pw = m_wr; pa = beat(m_base, m_cnt, order); pbe = be; kind = "R8";
         end else begin
            pv = 1'b0; kind = "R9";
         end
      end
   endtask

   // shorthand: enabled, selected load
   task automatic ld(input logic rw, input logic [NB-1:0] be, input logic [AW-1:0] a,
                     input string tag);
      cyc(0, 0, 0, 0, 0, 1, 0, rw, be, a, 0, tag);
   endtask
   task automatic step(input logic rw, input logic [NB-1:0] be, input string tag);
      cyc(0, 0, 0, 0, 0, 1, 1, rw, be, '0, 0, tag);
   endtask

   task automatic random_run(input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] u;
         u = $urandom();
         cyc(0, (u[3:0] == 4'd0), (u[7:4] == 4'd1), (u[11:8] == 4'd2), (u[11:8] == 4'd3),
             !(u[11:8] == 4'd4), (u[13:12] != 2'd0) && u[14], u[15], u[19:16], u[25:20],
             (u[29:26] == 4'd5), "");
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < D; i++) m_mem[i] = '0;
      cyc(1, 0, 0, 0, 0, 1, 1, 1, '1, '0, 0, "");
      cyc(1, 0, 0, 0, 0, 1, 1, 1, '1, '0, 0, "");
      // idle after reset
      step(1, '0, "R12");
      step(1, '0, "R9");
      // fill the array with full-word writes, back to back
      for (int i = 0; i < D; i++) ld(0, '0, AW'(i), "");
      // R1: write then read next edge, then write again
      ld(0, '0, 6'd5, "R12");
      ld(1, '0, 6'd5, "R1");
      ld(0, 4'b0101, 6'd6, "R1");
      ld(1, '0, 6'd6, "R5");
      ld(1, '0, 6'd6, "R6");
      // deselect, idle advance, R7 read with be_n low changed nothing
      cyc(0, 0, 0, 0, 0, 0, 0, 1, '0, 6'd7, 0, "R7");
      step(1, '0, "R4");
      ld(1, '1, 6'd6, "R9");
      // R7: burst write with rd_wr high on advance beats
      ld(0, '0, 6'd9, "R7");
      step(1, '0, "R5");
      step(1, '0, "R5");
      step(1, '0, "R5");
      ld(1, '1, 6'd9, "R5");
      step(0, '1, "R7");
      step(0, '1, "R8");
      step(0, '1, "R8");
      // R3 / R11 freeze mid-stream
      ld(1, '1, 6'd3, "R8");
      cyc(0, 1, 0, 1, 1, 0, 0, 0, '0, 6'd40, 0, "R2");
      cyc(0, 0, 1, 0, 0, 1, 0, 0, '0, 6'd41, 0, "R3");
      ld(0, '0, 6'd12, "R11");
      cyc(0, 1, 0, 0, 0, 1, 0, 1, '0, 6'd12, 0, "R3");
      cyc(0, 0, 1, 0, 0, 1, 0, 1, '0, 6'd12, 0, "R3");
      ld(1, '1, 6'd12, "R3");
      ld(1, '1, 6'd12, "R11");
      // R10
      cyc(0, 0, 0, 0, 0, 1, 1, 1, '1, '0, 1, "R10");
      // R12: array kept over reset
      ld(0, '0, 6'd20, "R2");
      cyc(1, 0, 0, 0, 0, 1, 1, 1, '1, '0, 0, "R5");
      ld(1, '1, 6'd20, "R12");
      step(1, '1, "R12");
      random_run(3000);
      // interleaved order, changed only under reset
      cyc(1, 0, 0, 0, 0, 1, 1, 1, '1, '0, 0, "");
      order = 1'b1;
      cyc(1, 0, 0, 0, 0, 1, 1, 1, '1, '0, 0, "");
      ld(0, '0, 6'd30, "R12");
      step(1, '0, "R5");
      step(1, '0, "R5");
      step(1, '0, "R5");
      ld(1, '1, 6'd30, "R5");
      step(1, '1, "R2");
      step(1, '1, "R8");
      step(1, '1, "R8");
      ld(1, '1, 6'd31, "R8");
      random_run(3000);
      step(1, '1, "");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(190000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule